// File: doc/BRIEF.md
# Vector Wide-Count Shift Unit

The block shifts every narrow element of a vector operand by a count taken from a second vector operand. The second operand is read as a row of 64-bit counts, one for each 64-bit granule. Each count is applied to every 8-, 16- or 32-bit element of the first operand that sits in the same granule. Three operations are available: logical left, logical right, and arithmetic right. The count is an unsigned 64-bit quantity. A count at or above the element width therefore clears the element for the logical shifts, and fills it with copies of its sign bit for the arithmetic shift.

The vector holds `NUM_GRANULES` granules. An active-length input gives the number of granules to compute, counted from the least significant end. Every granule above that length is written as zero. One operation is accepted per cycle. The result is registered and appears one cycle after the request, together with a valid flag.

Top module: `vec_wide_shift`

## Requirements
- R1: While rst_ni is low, and until the first accepted request after reset, out_valid_o is 0 and result_o is all zeros.
- R2: out_valid_o equals in_valid_i of the previous cycle. result_o is loaded only in a cycle with in_valid_i high, and holds its value in every other cycle.
- R3: Granule g covers bits [64g+63:64g] of both operands. Every element in granule g of op_a_i is shifted by the whole 64-bit value op_b_i[64g+63:64g].
- R4: esize_i selects the element width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits. Elements are packed little-endian, so element k of width W occupies bits [W*k+W-1:W*k].
- R5: op_i = 2 shifts each element left and fills the vacated low bits with zeros.
- R6: op_i = 1 shifts each element right as an unsigned value and fills the vacated high bits with zeros.
- R7: op_i = 0 shifts each element right as a two's complement value and fills the vacated high bits with copies of the element's sign bit.
- R8: If a granule count is greater than or equal to the element width, including any count with a bit set above bit 31, then op_i = 1 and op_i = 2 give zero, and op_i = 0 gives every bit equal to the element's sign bit.
- R9: act_len_i is a granule count. Every granule g with g >= act_len_i is zero in the result. A value above NUM_GRANULES makes all granules active.
- R10: op_i = 3 or esize_i = 3 yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| op_a_i | input | 64*NUM_GRANULES | Elements to shift |
| op_b_i | input | 64*NUM_GRANULES | One 64-bit count for each granule |
| esize_i | input | 2 | Element width select |
| op_i | input | 2 | Shift kind select |
| act_len_i | input | clog2(NUM_GRANULES+1) | Number of active granules |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64*NUM_GRANULES | Registered result vector |

## Verification
The bench builds the block with the default of four granules, which gives a 256-bit vector and a 3-bit length field. With these values every length from zero up to three past full is reachable, including the values above NUM_GRANULES that must saturate. Four granules also let each granule carry a different count in the same request, so a count that leaked across a granule boundary would show. The counts include the element width, the element width minus one, and values with only bit 32 or only bit 63 set. These sit on the edge of the saturation rule for each element size.

// File: rtl/vws_pkg.sv
package vws_pkg;
  localparam int GRAN_W = 64;

  typedef enum logic [1:0] {
    OP_ASR = 2'd0,
    OP_LSR = 2'd1,
    OP_LSL = 2'd2,
    OP_RSV = 2'd3
  } shift_op_e;

  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_H   = 2'd1,
    SZ_W   = 2'd2,
    SZ_RSV = 2'd3
  } elem_size_e;
endpackage

// File: rtl/vws_elem_shift.sv
module vws_elem_shift #(
  parameter int EW = 8
) (
  input  logic [EW-1:0]         data_i,
  input  logic [63:0]           cnt_i,
  input  vws_pkg::shift_op_e    op_i,
  output logic [EW-1:0]         res_o
);
  localparam int SW = $clog2(EW);

  logic          over;
  logic [SW-1:0] sh;

  // any count bit at or above log2(EW) saturates the shift
  assign over = |cnt_i[63:SW];
  assign sh   = cnt_i[SW-1:0];

  always_comb begin
    case (op_i)
      vws_pkg::OP_ASR: res_o = over ? {EW{data_i[EW-1]}} : EW'($signed(data_i) >>> sh);
      vws_pkg::OP_LSR: res_o = over ? '0 : (data_i >> sh);
      vws_pkg::OP_LSL: res_o = over ? '0 : (data_i << sh);
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/vws_granule.sv
module vws_granule (
  input  logic [63:0]          data_i,
  input  logic [63:0]          cnt_i,
  input  vws_pkg::shift_op_e   op_i,
  input  vws_pkg::elem_size_e  size_i,
  output logic [63:0]          res_o
);
  localparam int NUM_SZ = 3;

  logic [NUM_SZ-1:0][63:0] per_sz;

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int NE = vws_pkg::GRAN_W / EW;
    logic [63:0] sz_res;
    for (genvar e = 0; e < NE; e++) begin : g_el
      vws_elem_shift #(.EW(EW)) i_elem (
        .data_i (data_i[e*EW +: EW]),
        .cnt_i  (cnt_i),
        .op_i   (op_i),
        .res_o  (sz_res[e*EW +: EW])
      );
    end
    assign per_sz[s] = sz_res;
  end

  always_comb begin
    case (size_i)
      vws_pkg::SZ_B: res_o = per_sz[0];
      vws_pkg::SZ_H: res_o = per_sz[1];
      vws_pkg::SZ_W: res_o = per_sz[2];
      default:       res_o = '0;
    endcase
  end
endmodule

// File: rtl/vws_len_mask.sv
module vws_len_mask #(
  parameter int NUM_GRANULES = 4,
  parameter int LEN_W        = $clog2(NUM_GRANULES + 1)
) (
  input  logic [LEN_W-1:0]        act_len_i,
  output logic [NUM_GRANULES-1:0] gran_en_o
);
  for (genvar g = 0; g < NUM_GRANULES; g++) begin : g_en
    assign gran_en_o[g] = act_len_i > LEN_W'(g);
  end
endmodule

// File: rtl/vec_wide_shift.sv
module vec_wide_shift #(
  parameter int NUM_GRANULES = 4,
  localparam int VEC_W       = 64 * NUM_GRANULES,
  localparam int LEN_W       = $clog2(NUM_GRANULES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [VEC_W-1:0] op_a_i,
  input  logic [VEC_W-1:0] op_b_i,
  input  logic [1:0]       esize_i,
  input  logic [1:0]       op_i,
  input  logic [LEN_W-1:0] act_len_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] result_o
);
  vws_pkg::shift_op_e  op;
  vws_pkg::elem_size_e size;
  logic                rsv;

  assign op   = vws_pkg::shift_op_e'(op_i);
  assign size = vws_pkg::elem_size_e'(esize_i);
  assign rsv  = (op == vws_pkg::OP_RSV) || (size == vws_pkg::SZ_RSV);

  logic [NUM_GRANULES-1:0]       gran_en;
  logic [NUM_GRANULES-1:0][63:0] gran_res;
  logic [VEC_W-1:0]              nxt_res;

  vws_len_mask #(.NUM_GRANULES(NUM_GRANULES), .LEN_W(LEN_W)) i_len_mask (
    .act_len_i (act_len_i),
    .gran_en_o (gran_en)
  );

  for (genvar g = 0; g < NUM_GRANULES; g++) begin : g_gran
    vws_granule i_granule (
      .data_i (op_a_i[g*64 +: 64]),
      .cnt_i  (op_b_i[g*64 +: 64]),
      .op_i   (op),
      .size_i (size),
      .res_o  (gran_res[g])
    );
    assign nxt_res[g*64 +: 64] = (gran_en[g] && !rsv) ? gran_res[g] : 64'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= nxt_res;
    end
  end
endmodule

// File: rtl/vws_checker.sv
module vws_checker #(
  parameter int NUM_GRANULES = 4,
  localparam int VEC_W       = 64 * NUM_GRANULES,
  localparam int LEN_W       = $clog2(NUM_GRANULES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [VEC_W-1:0] op_a_i,
  input logic [VEC_W-1:0] op_b_i,
  input logic [1:0]       esize_i,
  input logic [1:0]       op_i,
  input logic [LEN_W-1:0] act_len_i,
  input logic             out_valid_o,
  input logic [VEC_W-1:0] result_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R2
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o)); // R2
  AST_EMPTY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && act_len_i == '0) |=> result_o == '0); // R9
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (op_i == 2'd3 || esize_i == 2'd3)) |=> result_o == '0); // R10
  AST_LSL_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 2'd2 && esize_i != 2'd3 && act_len_i != '0 && |op_b_i[63:32])
      |=> result_o[63:0] == 64'd0); // R8
  AST_ASR_OVER_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 2'd0 && esize_i == 2'd0 && act_len_i != '0 && |op_b_i[63:3])
      |=> result_o[7:0] == {8{$past(op_a_i[7])}}); // R8
endmodule

bind vec_wide_shift vws_checker #(.NUM_GRANULES(NUM_GRANULES)) i_vws_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_a_i      (op_a_i),
  .op_b_i      (op_b_i),
  .esize_i     (esize_i),
  .op_i        (op_i),
  .act_len_i   (act_len_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o)
);

// File: tb/test_vec_wide_shift.sv
module test_vec_wide_shift;
  localparam int NG    = 4;
  localparam int VW    = 64 * NG;
  localparam int LW    = $clog2(NG + 1);
  localparam int WDOG  = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] op_a = '0;
  logic [VW-1:0] op_b = '0;
  logic [1:0]    esize = '0;
  logic [1:0]    op = '0;
  logic [LW-1:0] act_len = '0;
  logic          out_valid;
  logic [VW-1:0] result;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string cur_req  = "R1";
  string exp_req  = "R1";
  logic          exp_v = 1'b0;
  logic [VW-1:0] exp_r = '0;

  always #5 clk = ~clk;

  vec_wide_shift #(.NUM_GRANULES(NG)) i_vec_wide_shift (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_a_i(op_a), .op_b_i(op_b),
    .esize_i(esize), .op_i(op), .act_len_i(act_len), .out_valid_o(out_valid), .result_o(result)
  );

  function automatic logic [VW-1:0] ref_calc(logic [VW-1:0] a, logic [VW-1:0] b,
                                             int sz, int kind, int len);
    logic [VW-1:0] r;
    int ew, ne;
    r = '0;
    if (sz == 3 || kind == 3) return r;
    ew = 8 << sz;
    ne = VW / ew;
    for (int i = 0; i < ne; i++) begin
      logic [63:0] c, v, mask, o, sx;
      logic        sgn;
      int          g;
      g = (i * ew) / 64;
      if (g >= len) continue;
      c    = b[g*64 +: 64];
      mask = (64'd1 << ew) - 64'd1;
      v    = 64'(a >> (i * ew)) & mask;
      sgn  = v[ew-1];
      if (kind == 2)      o = (c >= 64'(ew)) ? 64'd0 : ((v << c) & mask);
      else if (kind == 1) o = (c >= 64'(ew)) ? 64'd0 : (v >> c);
      else begin
        sx = sgn ? (v | ~mask) : v;
        o  = (c >= 64'(ew)) ? (sgn ? mask : 64'd0) : (64'($signed(sx) >>> c) & mask);
      end
      r = r | (VW'(o) << (i * ew));
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v   <= 1'b0;
      exp_r   <= '0;
      exp_req <= "R1";
    end else begin
      cycles  <= cycles + 1;
      exp_v   <= in_valid;
      exp_req <= cur_req;
      if (in_valid) exp_r <= ref_calc(op_a, op_b, int'(esize), int'(op), int'(act_len));
    end
  end

  always @(negedge clk) begin
    string tag;
    tag = rst_n ? exp_req : "R1";
    n_checks++;
    if (out_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s R2 out_valid actual=%b expected=%b", tag, out_valid, exp_v);
    end
    n_checks++;
    if (result !== exp_r) begin
      n_fail++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, exp_r);
    end
  end

  initial begin
    @(posedge clk);
    while (cycles < WDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic send(logic [VW-1:0] a, logic [VW-1:0] b, int sz, int kind, int len, string req);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a; op_b = b; esize = 2'(sz); op = 2'(kind); act_len = LW'(len);
    cur_req = req;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = rand_vec(); op_b = rand_vec(); op = 2'($urandom); esize = 2'($urandom);
      cur_req = "R2";
    end
  endtask

  initial begin
    logic [VW-1:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R3 R4 R5 R6 R7: in-range counts, a different count per granule
    for (int kind = 0; kind < 3; kind++)
      for (int sz = 0; sz < 3; sz++)
        for (int it = 0; it < 8; it++) begin
          for (int g = 0; g < NG; g++) b[g*64 +: 64] = 64'($urandom_range(0, (8 << sz) - 1));
          send(rand_vec(), b, sz, kind, NG,
               kind == 0 ? "R3 R4 R7" : (kind == 1 ? "R3 R4 R6" : "R3 R4 R5"));
        end
    // R8: counts at and around the saturation edge
    for (int kind = 0; kind < 3; kind++)
      for (int sz = 0; sz < 3; sz++)
        for (int it = 0; it < 4; it++) begin
          b[63:0]    = 64'(8 << sz);
          b[127:64]  = 64'((8 << sz) - 1);
          b[191:128] = 64'h0000_0001_0000_0000;
          b[255:192] = 64'h8000_0000_0000_0000 | 64'(it);
          send(rand_vec(), b, sz, kind, NG, "R8");
          b[63:0] = {$urandom, $urandom};
          b[63:60] = 4'h0;
          send(rand_vec(), b, sz, kind, NG, "R8");
        end
    // R9: every length, including past full
    for (int len = 0; len < (1 << LW); len++)
      for (int kind = 0; kind < 3; kind++) begin
        for (int g = 0; g < NG; g++) b[g*64 +: 64] = 64'($urandom_range(0, 9));
        send(rand_vec(), b, $urandom_range(0, 2), kind, len, "R9");
      end
    // R10: reserved encodings
    for (int it = 0; it < 3; it++) begin
      send(rand_vec(), rand_vec() & {NG{64'h7}}, it, 3, NG, "R10");
      send(rand_vec(), rand_vec() & {NG{64'h7}}, 3, it, NG, "R10");
    end
    // R2: hold through idle cycles, back-to-back then gaps
    send(rand_vec(), {NG{64'd3}}, 1, 2, NG, "R2");
    idle(4);
    send(rand_vec(), {NG{64'd1}}, 0, 0, NG, "R2");
    send(rand_vec(), {NG{64'd2}}, 2, 1, NG, "R2");
    idle(3);
    // R1: reset again clears outputs
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    cur_req = "R1";
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule